// File: doc/BRIEF.md
# Channel Command Word Checker

This block judges one already-fetched channel command word and tells the channel engine what to do next. Each decode request presents an 8-bit command code, an 8-bit flag byte, a 16-bit byte count, the address the word was fetched from and its 32-bit data address. One cycle later the block returns a registered outcome: continue with another word, program done, suspended, invalid, unsupported, or count error. It also returns the address of the next word to fetch, whether a length check is in force for the transfer, and the residual count left after a sense transfer.

The block keeps a single bit of history, which records whether the last accepted command was a transfer-in-channel (a jump within the program). That bit forbids two jumps in a row. The channel engine pulses a start strobe at the beginning of every new program, and this clears the history. Fetching words from memory and running device-specific commands are the engine's work. Every command code the block does not know is reported as unsupported.

Top module: `ccw_checker`

## Requirements
- R1: A command code whose low four bits are all zero gives outcome invalid (encoding 3).
- R2: A command code whose low four bits equal 8 and whose high four bits are not zero gives outcome invalid.
- R3: The code checks of R1 and R2 come first. After them, a set suspend flag (flag bit 1) gives outcome suspended (encoding 2), next address 0 and no change to the history.
- R4: The jump command 0x08 gives outcome invalid in three cases: the history bit is set, command-chain (flag bit 6) is set, or data-chain (flag bit 7) is set.
- R5: A legal jump 0x08 gives outcome continue (encoding 0) and sets the next address to the data address.
- R6: Every response drives len_check low exactly when suppress-length (flag bit 5) is set and data-chain (flag bit 7) is clear.
- R7: The no-op 0x03, basic sense 0x04 and identify 0xE4 commands, once accepted, give outcome continue with next address = fetch address + 8 when command-chain is set. Otherwise they give outcome done (encoding 1) with next address 0.
- R8: When len_check is high, basic sense with a count other than SENSE_LEN (32) gives outcome count error (encoding 5). Identify with a count other than IDENT_LEN (40) gives the same outcome.
- R9: An accepted sense or identify command reports residual = count minus the smaller of count and its buffer size. Every other response reports residual 0.
- R10: Any other command code that passes R1 and R2 gives outcome unsupported (encoding 4).
- R11: The history bit is set by an accepted jump and cleared by any other accepted command or by the start strobe. Outcomes invalid, unsupported, count error and suspended leave it unchanged. A start strobe in the same cycle as a request clears the history before that request is judged.
- R12: Each request gives rsp_valid high for exactly the following cycle, with all results registered at that edge. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New-program strobe, clears the jump history |
| req | input | 1 | Decode request |
| cmd | input | 8 | Command code |
| flags | input | 8 | Flag byte |
| count | input | CNT_W | Byte count |
| cur_addr | input | ADDR_W | Address the word was fetched from |
| data_addr | input | ADDR_W | Data address field of the word |
| rsp_valid | output | 1 | Response strobe |
| outcome | output | 3 | Outcome code |
| next_addr | output | ADDR_W | Address of the next word on continue |
| len_check | output | 1 | Length check in force |
| residual | output | CNT_W | Bytes left untransferred by a sense command |

## Verification
The start strobe and a decode request can arrive in the same cycle. This is the case most likely to go wrong, because the history must be cleared before the request is judged, and an accepted jump in that request must then set the history again. The bench provokes it directly: it sends a jump, then a second jump that carries the strobe, which must be accepted, and then a third jump without the strobe, which must be rejected. Random traffic also raises the strobe on about one request in eight, mixed with back-to-back jumps. A bench model applies the clear before it judges the request, and every response is compared with that model.

// File: rtl/ccw_chk_pkg.sv
package ccw_chk_pkg;
  typedef enum logic [2:0] {
    OC_CONTINUE = 3'd0,
    OC_DONE     = 3'd1,
    OC_SUSPEND  = 3'd2,
    OC_INVALID  = 3'd3,
    OC_UNSUPP   = 3'd4,
    OC_CNTERR   = 3'd5
  } outcome_e;

  typedef enum logic [2:0] {
    CL_BAD   = 3'd0,
    CL_JUMP  = 3'd1,
    CL_NOP   = 3'd2,
    CL_SENSE = 3'd3,
    CL_IDENT = 3'd4,
    CL_OTHER = 3'd5
  } cls_e;

  localparam int FB_DCHAIN  = 7;
  localparam int FB_CCHAIN  = 6;
  localparam int FB_NOLEN   = 5;
  localparam int FB_SUSPEND = 1;

  localparam logic [7:0] OP_JUMP  = 8'h08;
  localparam logic [7:0] OP_NOP   = 8'h03;
  localparam logic [7:0] OP_SENSE = 8'h04;
  localparam logic [7:0] OP_IDENT = 8'hE4;
endpackage

// File: rtl/ccw_code_classify.sv
module ccw_code_classify
  import ccw_chk_pkg::*;
(
  input  logic [7:0] cmd,
  output cls_e       cls
);
  localparam int NKNOWN = 3;
  localparam logic [NKNOWN-1:0][7:0] KNOWN_OPS = {OP_IDENT, OP_SENSE, OP_NOP};
  localparam cls_e KNOWN_CLS [NKNOWN] = '{CL_NOP, CL_SENSE, CL_IDENT};

  logic [NKNOWN-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NKNOWN; gi++) begin : g_match
      assign hit[gi] = (cmd == KNOWN_OPS[gi]);
    end
  endgenerate

  logic low_zero;
  logic jump_low;
  assign low_zero = (cmd[3:0] == 4'h0);
  assign jump_low = (cmd[3:0] == OP_JUMP[3:0]);

  always_comb begin
    cls = CL_OTHER;
    if (low_zero || (jump_low && (cmd[7:4] != 4'h0))) begin
      cls = CL_BAD;
    end else if (jump_low) begin
      cls = CL_JUMP;
    end else begin
      for (int k = 0; k < NKNOWN; k++) begin
        if (hit[k]) cls = KNOWN_CLS[k];
      end
    end
  end
endmodule

// File: rtl/ccw_rule_eval.sv
module ccw_rule_eval
  import ccw_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SENSE_LEN = 32,
  parameter int IDENT_LEN = 40,
  parameter int STRIDE    = 8
) (
  input  cls_e              cls,
  input  logic [7:0]        flags,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic              prev_jump,
  output outcome_e          outc,
  output logic [ADDR_W-1:0] nxt,
  output logic              lc,
  output logic [CNT_W-1:0]  resid,
  output logic              hist_we,
  output logic              hist_d
);
  localparam logic [CNT_W-1:0]  SLEN = CNT_W'(SENSE_LEN);
  localparam logic [CNT_W-1:0]  ILEN = CNT_W'(IDENT_LEN);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic             is_buf;
  logic [CNT_W-1:0] need;

  assign is_buf = (cls == CL_SENSE) || (cls == CL_IDENT);
  assign need   = (cls == CL_IDENT) ? ILEN : SLEN;
  assign lc     = !(flags[FB_NOLEN] && !flags[FB_DCHAIN]);

  always_comb begin
    outc    = OC_DONE;
    nxt     = '0;
    resid   = '0;
    hist_we = 1'b0;
    hist_d  = 1'b0;
    if (cls == CL_BAD) begin
      outc = OC_INVALID;
    end else if (flags[FB_SUSPEND]) begin
      outc = OC_SUSPEND;
    end else if (cls == CL_JUMP) begin
      if (prev_jump || flags[FB_CCHAIN] || flags[FB_DCHAIN]) begin
        outc = OC_INVALID;
      end else begin
        outc    = OC_CONTINUE;
        nxt     = data_addr;
        hist_we = 1'b1;
        hist_d  = 1'b1;
      end
    end else if (cls == CL_OTHER) begin
      outc = OC_UNSUPP;
    end else if (is_buf && lc && (count != need)) begin
      outc = OC_CNTERR;
    end else begin
      hist_we = 1'b1;
      hist_d  = 1'b0;
      if (is_buf && (count > need)) resid = count - need;
      if (flags[FB_CCHAIN]) begin
        outc = OC_CONTINUE;
        nxt  = cur_addr + STEP;
      end else begin
        outc = OC_DONE;
      end
    end
  end
endmodule

// File: rtl/ccw_jump_history.sv
module ccw_jump_history (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req,
  input  logic we,
  input  logic d,
  output logic prev_q,
  output logic prev_eff
);
  assign prev_eff = prev_q && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else if (req && we) begin
      prev_q <= d;
    end else if (start) begin
      prev_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ccw_checker.sv
module ccw_checker
  import ccw_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SENSE_LEN = 32,
  parameter int IDENT_LEN = 40,
  parameter int STRIDE    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req,
  input  logic [7:0]        cmd,
  input  logic [7:0]        flags,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] data_addr,
  output logic              rsp_valid,
  output logic [2:0]        outcome,
  output logic [ADDR_W-1:0] next_addr,
  output logic              len_check,
  output logic [CNT_W-1:0]  residual
);
  cls_e              cls;
  outcome_e          outc;
  logic [ADDR_W-1:0] nxt;
  logic              lc;
  logic [CNT_W-1:0]  resid;
  logic              hist_we;
  logic              hist_d;
  logic              prev_tic_q;
  logic              prev_eff;

  ccw_code_classify u_cls (
    .cmd (cmd),
    .cls (cls)
  );

  ccw_jump_history u_hist (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .req      (req),
    .we       (hist_we),
    .d        (hist_d),
    .prev_q   (prev_tic_q),
    .prev_eff (prev_eff)
  );

  ccw_rule_eval #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .SENSE_LEN (SENSE_LEN),
    .IDENT_LEN (IDENT_LEN),
    .STRIDE    (STRIDE)
  ) u_eval (
    .cls       (cls),
    .flags     (flags),
    .count     (count),
    .cur_addr  (cur_addr),
    .data_addr (data_addr),
    .prev_jump (prev_eff),
    .outc      (outc),
    .nxt       (nxt),
    .lc        (lc),
    .resid     (resid),
    .hist_we   (hist_we),
    .hist_d    (hist_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      outcome   <= '0;
      next_addr <= '0;
      len_check <= 1'b0;
      residual  <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        outcome   <= outc;
        next_addr <= nxt;
        len_check <= lc;
        residual  <= resid;
      end
    end
  end
endmodule

// File: rtl/ccw_checker_sva.sv
module ccw_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              req,
  input logic [7:0]        cmd,
  input logic [7:0]        flags,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] data_addr,
  input logic              rsp_valid,
  input logic [2:0]        outcome,
  input logic [ADDR_W-1:0] next_addr,
  input logic              len_check,
  input logic [CNT_W-1:0]  residual,
  input logic              hist
);
  assert_zero_nibble_R1: assert property (@(posedge clk) disable iff (rst)
    (req && cmd[3:0] == 4'h0) |=> (rsp_valid && outcome == 3'd3));

  assert_jump_high_R2: assert property (@(posedge clk) disable iff (rst)
    (req && cmd[3:0] == 4'h8 && cmd[7:4] != 4'h0) |=> (outcome == 3'd3));

  assert_jump_target_R5: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 8'h08 && !flags[7] && !flags[6] && !flags[1] && !hist)
      |=> (outcome == 3'd0 && next_addr == $past(data_addr)));

  assert_len_rule_R6: assert property (@(posedge clk) disable iff (rst)
    req |=> (len_check == !($past(flags[5]) && !$past(flags[7]))));

  assert_chain_step_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && outcome == 3'd0 && $past(cmd) != 8'h08)
      |-> (next_addr == $past(cur_addr) + ADDR_W'(8)));

  assert_resid_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (req && (cmd == 8'h03 || cmd == 8'h08)) |=> (residual == '0));

  assert_start_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !req) |=> !hist);

  assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);

  assert_code_range_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (outcome <= 3'd5));

  assert_count_touch_R8: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 8'h04 && !flags[1] && len_check == len_check && count == CNT_W'(32))
      |=> (outcome != 3'd5));
endmodule

bind ccw_checker ccw_checker_sva #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .req       (req),
  .cmd       (cmd),
  .flags     (flags),
  .count     (count),
  .cur_addr  (cur_addr),
  .data_addr (data_addr),
  .rsp_valid (rsp_valid),
  .outcome   (outcome),
  .next_addr (next_addr),
  .len_check (len_check),
  .residual  (residual),
  .hist      (prev_tic_q)
);

// File: tb/ccw_checker_bench.sv
module ccw_checker_bench;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SLEN = 32;
  localparam int ILEN = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          req = 1'b0;
  logic [7:0]    cmd = '0;
  logic [7:0]    flags = '0;
  logic [CW-1:0] count = '0;
  logic [AW-1:0] cur_addr = '0;
  logic [AW-1:0] data_addr = '0;
  logic          rsp_valid;
  logic [2:0]    outcome;
  logic [AW-1:0] next_addr;
  logic          len_check;
  logic [CW-1:0] residual;

  int n_cmp = 0;
  int n_bad = 0;
  logic hist_m = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ccw_checker #(.ADDR_W(AW), .CNT_W(CW)) u_ccw_checker (
    .clk(clk), .rst(rst), .start(start), .req(req), .cmd(cmd), .flags(flags),
    .count(count), .cur_addr(cur_addr), .data_addr(data_addr),
    .rsp_valid(rsp_valid), .outcome(outcome), .next_addr(next_addr),
    .len_check(len_check), .residual(residual)
  );

  typedef struct packed {
    logic [2:0]    oc;
    logic [AW-1:0] na;
    logic          lc;
    logic [CW-1:0] rs;
    logic          upd;
    logic          newh;
  } exp_t;

  function automatic exp_t model(input logic [7:0] c, input logic [7:0] f,
                                 input logic [CW-1:0] n, input logic [AW-1:0] ca,
                                 input logic [AW-1:0] da, input logic h);
    exp_t e;
    int unsigned buflen;
    e = '0;
    e.lc = !(f[5] && !f[7]);
    buflen = (c == 8'hE4) ? ILEN : SLEN;
    if (c[3:0] == 4'h0) e.oc = 3'd3;
    else if (c[3:0] == 4'h8 && c[7:4] != 4'h0) e.oc = 3'd3;
    else if (f[1]) e.oc = 3'd2;
    else if (c == 8'h08) begin
      if (h || f[6] || f[7]) e.oc = 3'd3;
      else begin e.oc = 3'd0; e.na = da; e.upd = 1'b1; e.newh = 1'b1; end
    end else if (c != 8'h03 && c != 8'h04 && c != 8'hE4) e.oc = 3'd4;
    else if (c != 8'h03 && e.lc && int'(n) != int'(buflen)) e.oc = 3'd5;
    else begin
      e.upd = 1'b1;
      if (c != 8'h03 && int'(n) > int'(buflen)) e.rs = CW'(int'(n) - int'(buflen));
      if (f[6]) begin e.oc = 3'd0; e.na = ca + 32'd8; end
      else e.oc = 3'd1;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [2:0] oc, input logic [7:0] c);
    case (oc)
      3'd0: return (c == 8'h08) ? "R5" : "R7";
      3'd1: return "R7";
      3'd2: return "R3";
      3'd3: return (c == 8'h08) ? "R4" : "R1";
      3'd4: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at a negedge, compare at the following negedge (one register stage)
  task automatic issue(input logic [7:0] c, input logic [7:0] f, input logic [CW-1:0] n,
                       input logic [AW-1:0] ca, input logic [AW-1:0] da, input logic st,
                       input string tag);
    exp_t e;
    e = model(c, f, n, ca, da, hist_m && !st);
    if (e.upd) hist_m = e.newh;
    else if (st) hist_m = 1'b0;
    req = 1'b1; start = st; cmd = c; flags = f; count = n; cur_addr = ca; data_addr = da;
    @(negedge clk);
    chk(tag, "rsp_valid", AW'(rsp_valid), AW'(1'b1));
    chk(tag, "outcome", AW'(outcome), AW'(e.oc));
    chk(tag, "next_addr", next_addr, e.na);
    chk("R6", "len_check", AW'(len_check), AW'(e.lc));
    chk("R9", "residual", AW'(residual), AW'(e.rs));
  endtask

  task automatic idle();
    req = 1'b0; start = 1'b0;
    @(negedge clk);
    chk("R12", "rsp_valid idle", AW'(rsp_valid), AW'(1'b0));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12", "reset rsp_valid", AW'(rsp_valid), '0);
    chk("R12", "reset outcome", AW'(outcome), '0);
    chk("R12", "reset next_addr", next_addr, '0);

    // directed corners
    issue(8'h30, 8'h00, 16'd0, 32'h100, 32'h0, 1'b0, "R1");
    issue(8'h18, 8'h00, 16'd0, 32'h100, 32'h0, 1'b0, "R2");
    issue(8'h00, 8'h02, 16'd0, 32'h100, 32'h0, 1'b0, "R3");   // code check beats suspend
    issue(8'h03, 8'h42, 16'd0, 32'h100, 32'h0, 1'b0, "R3");   // suspended
    issue(8'h08, 8'h00, 16'd0, 32'h100, 32'h4000, 1'b0, "R5");
    issue(8'h08, 8'h00, 16'd0, 32'h4000, 32'h5000, 1'b0, "R4"); // jump after jump
    issue(8'h03, 8'h40, 16'd0, 32'h4000, 32'h0, 1'b0, "R7");    // clears history
    issue(8'h08, 8'h40, 16'd0, 32'h4008, 32'h6000, 1'b0, "R4"); // chain flag
    issue(8'h08, 8'h80, 16'd0, 32'h4008, 32'h6000, 1'b0, "R4"); // data chain
    issue(8'h08, 8'h00, 16'd0, 32'h4008, 32'h6000, 1'b0, "R11");
    issue(8'h55, 8'h00, 16'd0, 32'h6000, 32'h0, 1'b0, "R10");   // unsupported keeps history
    issue(8'h08, 8'h00, 16'd0, 32'h6000, 32'h7000, 1'b1, "R11"); // start same cycle
    issue(8'h08, 8'h00, 16'd0, 32'h7000, 32'h8000, 1'b0, "R11"); // rejected again
    issue(8'h04, 8'h00, 16'd16, 32'h7000, 32'h0, 1'b0, "R8");
    issue(8'h04, 8'h20, 16'd48, 32'h7000, 32'h0, 1'b0, "R9");
    issue(8'hE4, 8'h40, 16'd40, 32'h7000, 32'h0, 1'b0, "R7");
    issue(8'hE4, 8'hA0, 16'd44, 32'h7000, 32'h0, 1'b0, "R8");
    issue(8'hE4, 8'h20, 16'd20, 32'h7000, 32'h0, 1'b0, "R9");
    idle();
    start = 1'b1; req = 1'b0; hist_m = 1'b0;
    @(negedge clk);
    start = 1'b0;

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c;
      logic [7:0] f;
      logic [CW-1:0] n;
      logic st;
      case ($urandom % 8)
        0, 1: c = 8'h08;
        2: c = 8'h03;
        3: c = 8'h04;
        4: c = 8'hE4;
        5: c = {4'($urandom), 4'h0};
        6: c = {4'($urandom | 1), 4'h8};
        default: c = 8'($urandom);
      endcase
      f = 8'($urandom);
      if ($urandom % 4 != 0) f[1] = 1'b0;
      if ($urandom % 2 == 0) f[7] = 1'b0;
      case ($urandom % 4)
        0: n = CW'(SLEN);
        1: n = CW'(ILEN);
        default: n = CW'($urandom % 96);
      endcase
      st = ($urandom % 8 == 0);
      issue(c, f, n, 32'($urandom) & ~32'h7, 32'($urandom), st,
            tag_of(model(c, f, n, 32'h0, 32'h0, hist_m && !st).oc, c));
      if ($urandom % 16 == 0) idle();
    end
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule